// File: doc/BRIEF.md
# Load-Store Byte Lane Unit

This unit sits between the execute stage of a 32-bit core and its data memory port. Each cycle it can take one memory operation, given as a 6-bit opcode, a base register value, a 16-bit signed offset and the register value to be stored. It forms the effective address and decodes the access size. For stores it drives a per-byte write enable and places copies of the store data on the write bus. It registers this request for one cycle toward the memory.

On the return side, the unit takes the 32-bit word read from memory. It uses the registered access size and low address bits to select the target byte or halfword. It then widens that value to 32 bits, with sign or zero extension as the opcode demands. An access whose address does not fit its size raises a flag and does not reach memory.

Top module: `mem_lane_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every output is zero.
- R2: One cycle after a request is presented, `mem_addr` equals `req_base` plus `req_ofs` sign-extended to 32 bits, modulo 2^32. This holds for every request, valid or not.
- R3: The opcodes that start an access are 0x20 (signed byte load), 0x24 (unsigned byte load), 0x21 (signed halfword load), 0x25 (unsigned halfword load), 0x23 (word load), 0x28 (byte store), 0x29 (halfword store) and 0x2b (word store). An aligned load raises `mem_re` one cycle later, and an aligned store raises `mem_we` one cycle later. Any other opcode, or `req_valid` low, gives `mem_re`=0, `mem_we`=0, `mem_be`=0 and `misalign`=0.
- R4: Lanes are big-endian, and `mem_be` bit 3 is the lane of bits 31:24. A byte store at low address bits k sets only bit 3-k. A halfword store sets 1100 at offset 0 and 0011 at offset 2. A word store sets 1111. `mem_be` is 0000 when no store is issued.
- R5: On a store, `mem_wdata` carries the low byte of `req_store` in all four lanes for a byte store, the low halfword twice for a halfword store, and the whole word for a word store. It is zero when no store is issued.
- R6: A halfword access with address bit 0 set, or a word access with either of address bits 1:0 set, gives `misalign`=1 one cycle later, with `mem_re`, `mem_we` and `mem_be` all zero. A byte access is never misaligned.
- R7: For a read issued in the previous cycle, `load_data` takes its value from `mem_rdata` bits [31-8k -: 8] for a byte at offset k. For a halfword it takes bits 31:16 at offset 0 and bits 15:0 at offset 2. For a word it takes the whole word.
- R8: Opcodes 0x20 and 0x21 sign-extend the selected value to 32 bits. Opcodes 0x24 and 0x25 zero-extend it.
- R9: `load_data` is zero whenever `mem_re` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An operation is presented this cycle |
| req_op | input | 6 | Primary opcode of the operation |
| req_base | input | 32 | Base register value |
| req_ofs | input | 16 | Signed address offset |
| req_store | input | 32 | Register value to be stored |
| mem_addr | output | 32 | Registered effective address |
| mem_we | output | 1 | Write strobe toward memory |
| mem_re | output | 1 | Read strobe toward memory |
| mem_be | output | 4 | Per-lane write enable, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-replicated store data |
| misalign | output | 1 | The previous request was misaligned |
| mem_rdata | input | 32 | Word returned by memory for the current read |
| load_data | output | 32 | Selected and extended load result |

## Verification
The assertions assume that `mem_rdata` is valid in the same cycle that `mem_re` is high. The bench meets this by driving the read word between clock edges, right after the strobe appears. The assertions also assume that the opcode is stable across a clock edge. Opcodes come from the eight access codes plus nearby unused codes, such as 0x22 and 0x2a. Base and offset values are chosen to reach every low-address combination, negative offsets and address wrap-around.

// File: rtl/mem_lane_unit.sv
module mem_lane_unit #(
  parameter int AW   = 32,
  parameter int OFSW = 16,
  parameter int OPW  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [OPW-1:0] req_op,
  input  logic [AW-1:0] req_base,
  input  logic [OFSW-1:0] req_ofs,
  input  logic [31:0]   req_store,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  output logic          misalign,
  input  logic [31:0]   mem_rdata,
  output logic [31:0]   load_data
);
  localparam logic [1:0] SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2;

  logic          is_ld, is_st, sx;
  logic [1:0]    sz;
  logic [AW-1:0] ea;
  logic          mis_c;
  logic [3:0]    be_c;
  logic [31:0]   wd_c;
  logic [1:0]    q_sz, q_lane;
  logic          q_sx;

  always_comb begin
    is_ld = 1'b0; is_st = 1'b0; sx = 1'b0; sz = SZ_W;
    if (req_valid) begin
      case (req_op)
        6'h20: begin is_ld = 1'b1; sz = SZ_B; sx = 1'b1; end
        6'h24: begin is_ld = 1'b1; sz = SZ_B; end
        6'h21: begin is_ld = 1'b1; sz = SZ_H; sx = 1'b1; end
        6'h25: begin is_ld = 1'b1; sz = SZ_H; end
        6'h23: begin is_ld = 1'b1; sz = SZ_W; end
        6'h28: begin is_st = 1'b1; sz = SZ_B; end
        6'h29: begin is_st = 1'b1; sz = SZ_H; end
        6'h2b: begin is_st = 1'b1; sz = SZ_W; end
        default: ;
      endcase
    end
  end

  assign ea    = req_base + {{(AW-OFSW){req_ofs[OFSW-1]}}, req_ofs};
  assign mis_c = (is_ld | is_st) &
                 (((sz == SZ_H) & ea[0]) | ((sz == SZ_W) & (|ea[1:0])));

  always_comb begin
    case (sz)
      SZ_B:    begin be_c = 4'b1000 >> ea[1:0]; wd_c = {4{req_store[7:0]}}; end
      SZ_H:    begin be_c = ea[1] ? 4'b0011 : 4'b1100; wd_c = {2{req_store[15:0]}}; end
      default: begin be_c = 4'b1111; wd_c = req_store; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr <= '0; mem_we <= 1'b0; mem_re <= 1'b0; mem_be <= '0;
      mem_wdata <= '0; misalign <= 1'b0; q_sz <= SZ_W; q_lane <= '0; q_sx <= 1'b0;
    end else begin
      mem_addr  <= ea;
      mem_we    <= is_st & ~mis_c;
      mem_re    <= is_ld & ~mis_c;
      mem_be    <= (is_st & ~mis_c) ? be_c : 4'b0000;
      mem_wdata <= (is_st & ~mis_c) ? wd_c : 32'd0;
      misalign  <= mis_c;
      q_sz      <= sz;
      q_lane    <= ea[1:0];
      q_sx      <= sx;
    end
  end

  logic [7:0]  sel_b;
  logic [15:0] sel_h;
  logic [31:0] ext;

  assign sel_b = mem_rdata[8*(3-q_lane) +: 8];
  assign sel_h = q_lane[1] ? mem_rdata[15:0] : mem_rdata[31:16];

  always_comb begin
    case (q_sz)
      SZ_B:    ext = {{24{q_sx & sel_b[7]}}, sel_b};
      SZ_H:    ext = {{16{q_sx & sel_h[15]}}, sel_h};
      default: ext = mem_rdata;
    endcase
  end

  assign load_data = mem_re ? ext : 32'd0;

  p_mis_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (mem_be == 4'b0000 && !mem_we && !mem_re));
  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, mem_re, misalign}));
  p_be_with_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_be != 4'b0000) == mem_we);
  p_byte_one_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && q_sz == SZ_B) |-> $countones(mem_be) == 1);
  p_half_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_we || mem_re) && q_sz != SZ_B) |-> !mem_addr[0]);
  p_idle_load_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_re |-> load_data == 32'd0);
  p_zero_ext_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && !q_sx && q_sz == SZ_B) |-> load_data[31:8] == 24'd0);
endmodule

// File: tb/mem_lane_unit_bench.sv
module mem_lane_unit_bench;
  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [5:0] req_op = 0;
  logic [31:0] req_base = 0, req_store = 0, mem_rdata = 0;
  logic [15:0] req_ofs = 0;
  logic [31:0] mem_addr, mem_wdata, load_data;
  logic mem_we, mem_re, misalign;
  logic [3:0] mem_be;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  mem_lane_unit u_mem_lane_unit (.*);

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  task automatic step(logic v, logic [5:0] op, logic [31:0] b, logic [15:0] o,
                      logic [31:0] st, logic [31:0] rd);
    int nb, lsb; bit ld, sgn, known, mis;
    logic [31:0] ea, ebe, ewd, eld;
    logic signed [15:0] so;
    req_valid = v; req_op = op; req_base = b; req_ofs = o; req_store = st;
    so = o; ea = b + 32'(int'(so));
    known = 1; ld = 0; sgn = 0; nb = 4;
    case (op)
      6'h20: begin ld = 1; sgn = 1; nb = 1; end
      6'h24: begin ld = 1; nb = 1; end
      6'h21: begin ld = 1; sgn = 1; nb = 2; end
      6'h25: begin ld = 1; nb = 2; end
      6'h23: begin ld = 1; nb = 4; end
      6'h28: nb = 1;
      6'h29: nb = 2;
      6'h2b: nb = 4;
      default: known = 0;
    endcase
    if (!v) known = 0;
    mis = known && (ea % nb) != 0;
    ebe = 0; ewd = 0; eld = 0;
    if (known && !mis && !ld) begin
      for (int i = 0; i < 4; i++) begin
        if (i >= ea[1:0] && i < ea[1:0] + nb) ebe[3-i] = 1;
        ewd[8*i +: 8] = st[8*(i % nb) +: 8];
      end
    end
    if (known && !mis && ld) begin
      lsb = 8 * (4 - ea[1:0] - nb);
      eld = rd >> lsb;
      if (nb < 4) begin
        eld = eld & ((32'd1 << (8*nb)) - 1);
        if (sgn && eld[8*nb-1]) eld = eld | ~((32'd1 << (8*nb)) - 1);
      end
    end
    @(negedge clk);
    mem_rdata = rd;
    #1;
    chk("R2", "addr", mem_addr, ea);
    chk("R3", "we", 32'(mem_we), 32'(known && !mis && !ld));
    chk("R3", "re", 32'(mem_re), 32'(known && !mis && ld));
    chk("R4", "be", 32'(mem_be), ebe);
    chk("R5", "wdata", mem_wdata, ewd);
    chk("R6", "misalign", 32'(misalign), 32'(mis));
    if (!(known && !mis && ld)) chk("R9", "load_data", load_data, eld);
    else if (sgn) chk("R8", "load_data", load_data, eld);
    else chk("R7", "load_data", load_data, eld);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [5:0] ops [10] = '{6'h20, 6'h24, 6'h21, 6'h25, 6'h23, 6'h28, 6'h29, 6'h2b, 6'h22, 6'h2a};
    repeat (3) @(negedge clk);
    chk("R1", "addr", mem_addr, 0);
    chk("R1", "strobes", {mem_we, mem_re, misalign, mem_be}, 0);
    chk("R1", "wdata", mem_wdata, 0);
    chk("R1", "load_data", load_data, 0);
    rst_n = 1;
    #1;
    chk("R1", "first cycle", {mem_we, mem_re, misalign, mem_be}, 0);
    for (int k = 0; k < 4; k++) begin
      step(1, 6'h28, 32'h1000, 16'(k), 32'hCAFE_BE5A, 32'h0);
      step(1, 6'h20, 32'h1000, 16'(k), 32'h0, 32'h8172_E39C);
      step(1, 6'h24, 32'h1000, 16'(k), 32'h0, 32'h8172_E39C);
      step(1, 6'h29, 32'h2000, 16'(k), 32'h1234_9ABC, 32'h0);
      step(1, 6'h21, 32'h2000, 16'(k), 32'h0, 32'h8001_7FFE);
      step(1, 6'h25, 32'h2000, 16'(k), 32'h0, 32'hF00F_9001);
      step(1, 6'h2b, 32'h3000, 16'(k), 32'hDEAD_BEEF, 32'h0);
      step(1, 6'h23, 32'h3000, 16'(k), 32'h0, 32'h0BAD_F00D);
    end
    step(1, 6'h23, 32'h0000_0010, 16'hFFF0, 32'h0, 32'h5555_AAAA);
    step(1, 6'h2b, 32'h0000_0004, 16'h8000, 32'h7777_1111, 32'h0);
    step(1, 6'h22, 32'h100, 16'h0, 32'h1, 32'hFFFF_FFFF);
    step(1, 6'h2a, 32'h100, 16'h0, 32'h1, 32'hFFFF_FFFF);
    step(0, 6'h2b, 32'h100, 16'h0, 32'h1, 32'hFFFF_FFFF);
    step(0, 6'h20, 32'h100, 16'h1, 32'h1, 32'hFFFF_FFFF);
    for (int n = 0; n < 400; n++)
      step(($urandom % 8) != 0, ops[$urandom % 10], $urandom, 16'($urandom),
           $urandom, $urandom);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule